// File: doc/BRIEF.md
# Table-Compensated Reciprocal Unit

This block returns the reciprocal of a normalized mantissa, rounded to nearest, without a full-width reciprocal table. A 13-bit fraction selects X = 1 + frac/8192. The upper fraction bits pick a segment. Inside that segment, a straight line with a slightly steep slope is evaluated as an array of AND partial products of the low fraction bits. The array is reduced in carry-save form.

A constant bias is folded into each segment's intercept, so the carry-save estimate never lies above the correctly rounded answer. A narrow compensation table, addressed by the whole fraction, supplies the unsigned amount still missing. Its contents are defined as the rounded reciprocal minus the bit-exact estimate for that address. The table lookup proceeds alongside the array.

One row of 3:2 compressors merges the estimate pair with the table word. One carry-propagate adder then produces the result. The offset width is a parameter. The segment count is derived from it, so that the spread of the estimate error fits the table word.

The unit takes one operand per clock. There is one register stage at the input and one at the output.

Top module: `recip_tc_unit`

## Requirements
- R1: For every in_frac (unsigned, 13 bits, X = 1 + in_frac/8192), out_data equals floor((2^25 + D) / (2*D)) with D = 8192 + in_frac. This is 2048/X rounded to the nearest integer; no ties can occur.
- R2: out_valid equals in_valid as sampled two rising edges earlier, and the matching out_data appears in the same cycle.
- R3: When no valid operand reaches the output stage, out_data keeps its previous value, whatever in_frac carries at the time.
- R4: While rst is high, out_valid and out_data are driven to 0 at each rising edge.
- R5: The carry-save estimate pair, summed modulo 2^12, never exceeds the rounded reciprocal of the operand it belongs to.
- R6: Every compensation word lies between 0 and 2^OFF_W - 1 (0 to 63 by default).
- R7: The registered result equals the sum of the estimate pair and the compensation word, modulo 2^12.
- R8: The endpoints are exact: in_frac = 0 yields 2048, and in_frac = 8191 yields 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_frac | input | 13 | Fraction bits of X, where X = 1 + in_frac/8192 |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 12 | Rounded value of 2048/X |

## Verification
Each result is due two rising edges after its operand is presented, one edge for the input register and one for the output register. The bench drives an operand on each falling edge. On that same falling edge, before it drives the next operand, it compares the outputs with the operand it drove two falling edges earlier. Idle cycles are inserted inside the exhaustive sweep, with changing fraction bits, so that the held-value rule is checked in the cycle where a result would otherwise have landed. The reset values are sampled on falling edges while reset is held.

// File: rtl/recip_tc_pkg.sv
package recip_tc_pkg;

    // fractional guard bits of the slope and of the partial-product array
    localparam int FR   = 20;
    localparam int MQ_W = FR - 1;

    // constant bias subtracted from a segment intercept for a given segment count
    function automatic int bias_for(input int in_w, input int s);
        int e;
        e = in_w - 4 - 2 * s;
        return (e >= 0) ? ((1 << e) + 2) : 2;
    endfunction

    // smallest segment-select width whose error spread fits an off_w-bit word
    function automatic int seg_bits_for(input int in_w, input int off_w);
        for (int s = 1; s < in_w - 1; s++) begin
            if (bias_for(in_w, s) + 2 <= (1 << off_w) - 1) return s;
        end
        return in_w - 2;
    endfunction

    // round-to-nearest of 2^(2*in_w-2) / D
    function automatic logic [63:0] rn_ref(input int in_w, input logic [63:0] frac);
        logic [63:0] d;
        d = (64'd1 << in_w) + frac;
        return ((64'd1 << (2 * in_w - 1)) + d) / (2 * d);
    endfunction

    // segment intercept with the bias folded in (+2 pays for two inversions)
    function automatic logic [63:0] base_of(input int in_w, input int s, input logic [63:0] seg);
        logic [63:0] d0;
        d0 = (64'd1 << in_w) + (seg << (in_w - s));
        return ((64'd1 << (2 * in_w - 2)) / d0) + 64'd2 - 64'(bias_for(in_w, s));
    endfunction

    // chord slope rounded up, scaled by 2^FR
    function automatic logic [63:0] slope_of(input int in_w, input int s, input logic [63:0] seg);
        logic [63:0] d0, d1, num, den;
        d0  = (64'd1 << in_w) + (seg << (in_w - s));
        d1  = d0 + (64'd1 << (in_w - s));
        num = 64'd1 << (2 * in_w - 2 + FR);
        den = d0 * d1;
        return (num + den - 64'd1) / den;
    endfunction

    // bit-exact model of the estimate datapath, used to fill the table
    function automatic logic [63:0] est_model(input int in_w, input int s, input logic [63:0] frac);
        int nt, ew, aw;
        logic [63:0] amask, emask, seg, t, mq, sv, cv, r, ns, nc;
        logic [63:0] a, b, na, nb, base, es, ec;
        nt    = in_w - s;
        ew    = in_w - 1;
        aw    = FR + ew;
        amask = (64'd1 << aw) - 64'd1;
        emask = (64'd1 << ew) - 64'd1;
        seg   = frac >> nt;
        t     = frac & ((64'd1 << nt) - 64'd1);
        mq    = slope_of(in_w, s, seg);
        sv    = t[0] ? mq : 64'd0;
        cv    = 64'd0;
        for (int i = 1; i < nt; i++) begin
            r  = t[i] ? (mq << i) : 64'd0;
            ns = (sv ^ cv ^ r) & amask;
            nc = (((sv & cv) | (sv & r) | (cv & r)) << 1) & amask;
            sv = ns;
            cv = nc;
        end
        a    = (sv >> FR) & emask;
        b    = (cv >> FR) & emask;
        na   = ~a & emask;
        nb   = ~b & emask;
        base = base_of(in_w, s, seg) & emask;
        es   = base ^ na ^ nb;
        ec   = (((base & na) | (base & nb) | (na & nb)) << 1) & emask;
        return (es + ec) & emask;
    endfunction

    // compensation word before narrowing (signed so range checks can see it)
    function automatic longint offset_wide(input int in_w, input int s, input logic [63:0] frac);
        return $signed(rn_ref(in_w, frac)) - $signed(est_model(in_w, s, frac));
    endfunction

endpackage

// File: rtl/recip_csa.sv
module recip_csa #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    // carry out of the top bit is dropped: callers keep sums inside W bits
    assign sum   = a ^ b ^ c;
    assign carry = {(a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0]), 1'b0};
endmodule

// File: rtl/recip_approx.sv
module recip_approx
    import recip_tc_pkg::*;
#(
    parameter int IN_W  = 13,
    parameter int SEG_W = 2
) (
    input  logic [IN_W-1:0] frac_i,
    output logic [IN_W-2:0] est_s_o,
    output logic [IN_W-2:0] est_c_o
);
    localparam int NT   = IN_W - SEG_W;
    localparam int EW   = IN_W - 1;
    localparam int AW   = FR + EW;
    localparam int SEGS = 1 << SEG_W;

    logic [MQ_W-1:0]  slope_tab [SEGS];
    logic [EW-1:0]    base_tab  [SEGS];
    logic [SEG_W-1:0] seg;
    logic [NT-1:0]    t;
    logic [MQ_W-1:0]  mq_sel;
    logic [EW-1:0]    base_sel;
    logic [EW-1:0]    a_tr, b_tr;
    logic             unused_low;

    for (genvar g = 0; g < SEGS; g++) begin : g_seg
        assign slope_tab[g] = MQ_W'(slope_of(IN_W, SEG_W, 64'(g)));
        assign base_tab[g]  = EW'(base_of(IN_W, SEG_W, 64'(g)));
    end

    assign seg      = frac_i[IN_W-1 -: SEG_W];
    assign t        = frac_i[NT-1:0];
    assign mq_sel   = slope_tab[seg];
    assign base_sel = base_tab[seg];

    // linear carry-save array: one row of AND terms per low fraction bit
    for (genvar i = 0; i < NT; i++) begin : g_stg
        logic [AW-1:0] row, s, c;
        assign row = t[i] ? (AW'(mq_sel) << i) : '0;
        if (i == 0) begin : g_first
            assign s = row;
            assign c = '0;
        end else begin : g_next
            recip_csa #(.W(AW)) u_csa (
                .a    (g_stg[i-1].s),
                .b    (g_stg[i-1].c),
                .c    (row),
                .sum  (s),
                .carry(c)
            );
        end
    end

    assign a_tr       = g_stg[NT-1].s[AW-1:FR];
    assign b_tr       = g_stg[NT-1].c[AW-1:FR];
    assign unused_low = ^{g_stg[NT-1].s[FR-1:0], g_stg[NT-1].c[FR-1:0]};

    // intercept minus both truncated rows, still in carry-save form
    recip_csa #(.W(EW)) u_sub (
        .a    (base_sel),
        .b    (~a_tr),
        .c    (~b_tr),
        .sum  (est_s_o),
        .carry(est_c_o)
    );
endmodule

// File: rtl/recip_comp_rom.sv
module recip_comp_rom
    import recip_tc_pkg::*;
#(
    parameter int IN_W  = 13,
    parameter int OFF_W = 6,
    parameter int SEG_W = 2
) (
    input  logic [IN_W-1:0]  addr_i,
    output logic [OFF_W-1:0] word_o
);
    longint raw;

    // word content is a constant function of the address only
    always_comb begin
        raw    = offset_wide(IN_W, SEG_W, 64'(addr_i));
        word_o = raw[OFF_W-1:0];
    end
endmodule

// File: rtl/recip_tc_unit.sv
module recip_tc_unit
    import recip_tc_pkg::*;
#(
    parameter int IN_W  = 13,
    parameter int OFF_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_frac,
    output logic              out_valid,
    output logic [IN_W-2:0]   out_data
);
    localparam int OUT_W = IN_W - 1;
    localparam int SEG_W = seg_bits_for(IN_W, OFF_W);

    logic              stg_valid;
    logic [IN_W-1:0]   stg_frac;
    logic [OUT_W-1:0]  est_s, est_c;
    logic [OFF_W-1:0]  off_word;
    logic [OUT_W-1:0]  mrg_s, mrg_c, result;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_valid <= 1'b0;
            stg_frac  <= '0;
        end else begin
            stg_valid <= in_valid;
            stg_frac  <= in_frac;
        end
    end

    recip_approx #(.IN_W(IN_W), .SEG_W(SEG_W)) u_approx (
        .frac_i (stg_frac),
        .est_s_o(est_s),
        .est_c_o(est_c)
    );

    recip_comp_rom #(.IN_W(IN_W), .OFF_W(OFF_W), .SEG_W(SEG_W)) u_rom (
        .addr_i(stg_frac),
        .word_o(off_word)
    );

    recip_csa #(.W(OUT_W)) u_merge (
        .a    (est_s),
        .b    (est_c),
        .c    (OUT_W'(off_word)),
        .sum  (mrg_s),
        .carry(mrg_c)
    );

    assign result = mrg_s + mrg_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= stg_valid;
            if (stg_valid) out_data <= result;
        end
    end
endmodule

// File: rtl/recip_tc_unit_chk.sv
module recip_tc_unit_chk
    import recip_tc_pkg::*;
#(
    parameter int IN_W  = 13,
    parameter int OFF_W = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            out_valid,
    input logic [IN_W-2:0] out_data,
    input logic            stg_valid,
    input logic [IN_W-1:0] stg_frac,
    input logic [IN_W-2:0] est_s,
    input logic [IN_W-2:0] est_c,
    input logic [OFF_W-1:0] off_word
);
    localparam int OUT_W = IN_W - 1;
    localparam int SEG_W = seg_bits_for(IN_W, OFF_W);

    logic             v1, v2, armed, rst_q;
    logic [OUT_W-1:0] est_sum, ref_val, mrg_expect;
    longint           off_chk;

    always_comb begin
        est_sum    = OUT_W'(est_s + est_c);
        ref_val    = OUT_W'(rn_ref(IN_W, 64'(stg_frac)));
        mrg_expect = OUT_W'(est_s + est_c + OUT_W'(off_word));
        off_chk    = offset_wide(IN_W, SEG_W, 64'(stg_frac));
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            v1    <= 1'b0;
            v2    <= 1'b0;
            armed <= 1'b1;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
        end
        if (rst_q) begin
            p_reset_state_r4: assert (out_valid == 1'b0 && out_data == '0)
                else $error("reset state not applied");
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> out_valid == v2);

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !stg_valid |=> $stable(out_data));

    p_under_est_r5: assert property (@(posedge clk) disable iff (rst)
        stg_valid |-> est_sum <= ref_val);

    p_word_range_r6: assert property (@(posedge clk) disable iff (rst)
        stg_valid |-> (off_chk >= 0 && off_chk <= longint'((1 << OFF_W) - 1)));

    p_merge_sum_r7: assert property (@(posedge clk) disable iff (rst)
        stg_valid |=> out_data == $past(mrg_expect));
endmodule

bind recip_tc_unit recip_tc_unit_chk #(.IN_W(IN_W), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_data (out_data),
    .stg_valid(stg_valid),
    .stg_frac (stg_frac),
    .est_s    (est_s),
    .est_c    (est_c),
    .off_word (off_word)
);

// File: tb/recip_tc_unit_tb.sv
module recip_tc_unit_tb;
    localparam int IN_W  = 13;
    localparam int OUT_W = IN_W - 1;
    localparam int MAXF  = (1 << IN_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_frac = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit pv [2];
    int pf [2];
    int held = 0;

    recip_tc_unit #(.IN_W(IN_W), .OFF_W(6)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_frac  (in_frac),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    always #4 clk = ~clk;

    // nearest integer to 2048/X, X = 1 + f/8192
    function automatic int ref_rn(input int f);
        longint d;
        d = longint'((1 << IN_W) + f);
        return int'(((64'sd1 <<< (2 * IN_W - 1)) + d) / (2 * d));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // check the operand from two steps back, then drive a new one
    task automatic step(input bit v, input int f);
        int e;
        @(negedge clk);
        chk(out_valid == pv[1], "R2 valid latency", int'(out_valid), int'(pv[1]));
        if (pv[1]) begin
            e = ref_rn(pf[1]);
            if (pf[1] == 0 || pf[1] == MAXF)
                chk(int'(out_data) == e, "R8 endpoint", int'(out_data), e);
            else
                chk(int'(out_data) == e, "R1 R5 R6 R7 rounded reciprocal", int'(out_data), e);
            held = e;
        end else begin
            chk(int'(out_data) == held, "R3 hold when idle", int'(out_data), held);
        end
        pv[1] = pv[0];
        pf[1] = pf[0];
        pv[0] = v;
        pf[0] = f;
        in_valid = v;
        in_frac  = IN_W'(f);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        pv[0] = 1'b0; pv[1] = 1'b0; pf[0] = 0; pf[1] = 0;
        // R4: outputs cleared while reset is held, even with activity on the inputs
        in_valid = 1'b1;
        in_frac  = IN_W'(777);
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R4 reset valid", int'(out_valid), 0);
            chk(out_data == '0, "R4 reset data", int'(out_data), 0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 reset valid", int'(out_valid), 0);
        rst = 1'b0;

        // R8 endpoints and neighbours, R3 with changing idle fraction bits
        step(1'b1, 0);
        step(1'b1, MAXF);
        step(1'b0, 4095);
        step(1'b0, 17);
        step(1'b1, 1);
        step(1'b0, MAXF);
        step(1'b1, MAXF - 1);
        step(1'b1, 1 << (IN_W - 1));

        // R1: exhaustive sweep with idle bubbles interleaved (R2, R3)
        for (int f = 0; f <= MAXF; f++) begin
            if (f % 97 == 50) step(1'b0, f ^ 5);
            step(1'b1, f);
        end

        // alternating pattern, then flush
        for (int k = 0; k < 16; k++) begin
            step(1'b1, (k * 523) & MAXF);
            step(1'b0, (k * 311) & MAXF);
        end
        step(1'b0, 0);
        step(1'b0, 0);
        step(1'b0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule